// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block walks a vector operation one sub-element per clock cycle and tells the execution side what to do at each position. For each step it raises exactly one of three indications: perform the element, write a zero in its place, or skip it. The element index and the sub-element index come with the indication. A start pulse captures the vector length, the sub-vector grouping code, the predicate kind, a 3-bit predicate selector, the zeroing bit and the predicate sources. From that point the run does not depend on the input pins.

The predicate is one bit per element. It comes from one of two places. The first is three 64-bit integer register values. These can be used with or without inversion, or in a mode where only the element whose index equals the first register's value is enabled. The second is a window of 4-bit condition fields, where one chosen flag is tested for set or for clear. Every sub-element of a group shares its element's predicate bit. A vector length of zero issues nothing and only reports completion.

Top module: `pred_elem_seq`

## Requirements
- R1: While idle, a `start` pulse captures the run settings. From the next cycle `busy` is high and one sub-element is presented per cycle. Element indices rise from 0, and within each element `sub_idx` rises from 0. A length above 64 is clamped to 64.
- R2: In every busy cycle exactly one of `elem_valid`, `elem_zero` and `elem_skip` is high. While idle all three are low.
- R3: Integer kind (`pred_kind`=0), bit i taken from the LSB side. Selector 000 enables every element. 010 and 011 use `src_r3` bit i true or inverted. 100 and 101 do the same with `src_r10`. 110 and 111 do the same with `src_r30`.
- R4: Integer selector 001 enables only the element whose index equals the full 64-bit value of `src_r3`. A value of 64 or more enables no element.
- R5: Condition kind (`pred_kind`=1). Element i tests the nibble `cond_fields[4*i+3:4*i]`, which is condition field 32+i. Within the nibble, bit 3 is LT, bit 2 GT, bit 1 EQ and bit 0 the summary-overflow flag. Selector pairs 00x, 01x, 10x and 11x pick LT, GT, EQ and SO in that order. An even code enables when the flag is set, and an odd code enables when it is clear.
- R6: Sub-vector code 00, 01, 10 or 11 gives groups of 1, 2, 3 or 4 sub-elements. All sub-elements of one element carry the same indication.
- R7: When an element's predicate bit is 0, it is issued as `elem_zero` if the zeroing bit was set at start, and as `elem_skip` otherwise.
- R8: A start with length 0 presents no sub-element. `done` pulses in the next cycle and `busy` stays low.
- R9: `done` is a one-cycle pulse in the cycle after the last sub-element of the last element, and `busy` is low in that cycle.
- R10: A `start` pulse during a run is ignored. The run continues with its original settings.
- R11: Predicate sources are sampled at start. Changing them during a run has no effect on that run.
- R12: Integer kind, selector 000, length 1 and sub-vector code 00 issue a single enabled element 0 with sub-index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture settings and begin a run (ignored while busy) |
| vec_len | input | 7 | Number of elements, 0 to 64 (larger values clamp) |
| subvec_code | input | 2 | Sub-vector group size minus one |
| pred_kind | input | 1 | 0 = integer predicate, 1 = condition-field predicate |
| pred_sel | input | 3 | Predicate selector code |
| zero_en | input | 1 | Issue masked elements as zero-fill instead of skipping |
| src_r3 | input | 64 | First integer predicate source |
| src_r10 | input | 64 | Second integer predicate source |
| src_r30 | input | 64 | Third integer predicate source |
| cond_fields | input | 256 | Condition fields 32 upward, 4 bits each, field 32 in the lowest nibble |
| busy | output | 1 | A run is in progress |
| elem_valid | output | 1 | Current sub-element is enabled |
| elem_zero | output | 1 | Current sub-element is to be zero-filled |
| elem_skip | output | 1 | Current sub-element is skipped |
| elem_idx | output | 6 | Current element index |
| sub_idx | output | 2 | Current sub-element index |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: 64 elements maximum, 64-bit integer sources and a 64-field condition window. These values make the top boundaries reachable. One case puts the one-hot match on element 63. Another gives a one-hot value past the last element, so nothing is enabled. A third asks for length 127, which must clamp to 64 steps. All four group sizes are covered, along with every integer and condition selector code and both the zero-fill and skip outcomes.

// File: rtl/pes_pkg.sv
package pes_pkg;

    // Integer predicate selector codes
    localparam logic [2:0] SEL_ALL    = 3'b000;
    localparam logic [2:0] SEL_ONEHOT = 3'b001;

    // Bit positions of the flags inside a 4-bit condition field
    localparam int FLAG_LT = 3;
    localparam int FLAG_GT = 2;
    localparam int FLAG_EQ = 1;
    localparam int FLAG_SO = 0;

    localparam int CF_BITS = 4;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_ISSUE = 2'd1,
        ACT_ZERO  = 2'd2,
        ACT_SKIP  = 2'd3
    } act_e;

endpackage

// File: rtl/pes_int_mask.sv
module pes_int_mask
    import pes_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int REG_W  = 64
) (
    input  logic [2:0]        sel,
    input  logic [REG_W-1:0]  r3,
    input  logic [REG_W-1:0]  r10,
    input  logic [REG_W-1:0]  r30,
    output logic [MAX_VL-1:0] mask
);

    for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
        logic src_bit;
        logic onehot_hit;

        if (i < REG_W) begin : g_in
            assign src_bit = (sel[2:1] == 2'd1) ? r3[i] :
                             (sel[2:1] == 2'd2) ? r10[i] : r30[i];
        end else begin : g_out
            assign src_bit = 1'b0;
        end

        assign onehot_hit = (r3 == REG_W'(i));

        assign mask[i] = (sel == SEL_ALL)    ? 1'b1 :
                         (sel == SEL_ONEHOT) ? onehot_hit :
                                               (src_bit ^ sel[0]);
    end

endmodule

// File: rtl/pes_cond_mask.sv
module pes_cond_mask
    import pes_pkg::*;
#(
    parameter int MAX_VL = 64
) (
    input  logic [2:0]                sel,
    input  logic [CF_BITS*MAX_VL-1:0] fields,
    output logic [MAX_VL-1:0]         mask
);

    for (genvar i = 0; i < MAX_VL; i++) begin : g_fld
        logic [CF_BITS-1:0] nib;
        logic               flag;

        assign nib = fields[CF_BITS*i +: CF_BITS];

        always_comb begin
            case (sel[2:1])
                2'd0:    flag = nib[FLAG_LT];
                2'd1:    flag = nib[FLAG_GT];
                2'd2:    flag = nib[FLAG_EQ];
                default: flag = nib[FLAG_SO];
            endcase
        end

        assign mask[i] = flag ^ sel[0];
    end

endmodule

// File: rtl/pes_step_ctrl.sv
module pes_step_ctrl
    import pes_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(MAX_VL + 1),
    parameter int IDX_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vec_len,
    input  logic [1:0]        subvec_code,
    input  logic              zero_en,
    input  logic [MAX_VL-1:0] mask_in,
    output logic              busy,
    output logic              elem_valid,
    output logic              elem_zero,
    output logic              elem_skip,
    output logic [IDX_W-1:0]  elem_idx,
    output logic [1:0]        sub_idx,
    output logic              done
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        sub;
        logic [IDX_W-1:0]  last_idx;
        logic [1:0]        sv_code;
        logic              zen;
        logic [MAX_VL-1:0] mask;
    } seq_t;

    seq_t st_d, st_q;

    logic [VL_W-1:0] eff_len;
    logic            last_sub;
    logic            last_elem;
    logic            pbit;
    act_e            act;

    assign eff_len   = (vec_len > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vec_len;
    assign last_sub  = (st_q.sub == st_q.sv_code);
    assign last_elem = (st_q.idx == st_q.last_idx);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                if (eff_len == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy     = 1'b1;
                    st_d.idx      = '0;
                    st_d.sub      = '0;
                    st_d.last_idx = IDX_W'(eff_len - VL_W'(1));
                    st_d.sv_code  = subvec_code;
                    st_d.zen      = zero_en;
                    st_d.mask     = mask_in;
                end
            end
        end else if (last_sub) begin
            st_d.sub = '0;
            if (last_elem) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end else begin
            st_d.sub = st_q.sub + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pbit = st_q.mask[st_q.idx];

    always_comb begin
        if (!st_q.busy)    act = ACT_NONE;
        else if (pbit)     act = ACT_ISSUE;
        else if (st_q.zen) act = ACT_ZERO;
        else               act = ACT_SKIP;
    end

    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign elem_valid = (act == ACT_ISSUE);
    assign elem_zero  = (act == ACT_ZERO);
    assign elem_skip  = (act == ACT_SKIP);
    assign elem_idx   = st_q.idx;
    assign sub_idx    = st_q.sub;

    p_sub_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sub_idx <= st_q.sv_code));

    p_group_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sub_idx != 2'd0) |-> ($stable(elem_valid) && $stable(elem_zero) && $stable(elem_idx)));

    p_step_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_sub) |=> (busy && elem_idx == $past(elem_idx) && sub_idx == $past(sub_idx) + 2'd1));

    p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot({elem_valid, elem_zero, elem_skip}));

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_sub && last_elem) |=> (done && !busy));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_empty_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && vec_len == '0) |=> (done && !busy));

    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(last_sub && last_elem)) |=> (busy && $stable(st_q.last_idx) && $stable(st_q.mask)));

endmodule

// File: rtl/pred_elem_seq.sv
module pred_elem_seq
    import pes_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int REG_W  = 64,
    localparam int VL_W  = $clog2(MAX_VL + 1),
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int CF_W  = CF_BITS * MAX_VL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vec_len,
    input  logic [1:0]        subvec_code,
    input  logic              pred_kind,
    input  logic [2:0]        pred_sel,
    input  logic              zero_en,
    input  logic [REG_W-1:0]  src_r3,
    input  logic [REG_W-1:0]  src_r10,
    input  logic [REG_W-1:0]  src_r30,
    input  logic [CF_W-1:0]   cond_fields,
    output logic              busy,
    output logic              elem_valid,
    output logic              elem_zero,
    output logic              elem_skip,
    output logic [IDX_W-1:0]  elem_idx,
    output logic [1:0]        sub_idx,
    output logic              done
);

    logic [MAX_VL-1:0] int_mask;
    logic [MAX_VL-1:0] cond_mask;
    logic [MAX_VL-1:0] sel_mask;

    pes_int_mask #(.MAX_VL(MAX_VL), .REG_W(REG_W)) u_int_mask (
        .sel  (pred_sel),
        .r3   (src_r3),
        .r10  (src_r10),
        .r30  (src_r30),
        .mask (int_mask)
    );

    pes_cond_mask #(.MAX_VL(MAX_VL)) u_cond_mask (
        .sel    (pred_sel),
        .fields (cond_fields),
        .mask   (cond_mask)
    );

    assign sel_mask = pred_kind ? cond_mask : int_mask;

    pes_step_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .vec_len     (vec_len),
        .subvec_code (subvec_code),
        .zero_en     (zero_en),
        .mask_in     (sel_mask),
        .busy        (busy),
        .elem_valid  (elem_valid),
        .elem_zero   (elem_zero),
        .elem_skip   (elem_skip),
        .elem_idx    (elem_idx),
        .sub_idx     (sub_idx),
        .done        (done)
    );

    p_identity_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !pred_kind && pred_sel == SEL_ALL && vec_len == VL_W'(1) && subvec_code == 2'd0)
        |=> (busy && elem_valid && elem_idx == '0 && sub_idx == 2'd0));

endmodule

// File: tb/pred_elem_seq_tb.sv
module pred_elem_seq_tb_top;

    localparam int NV = 20;

    typedef struct packed {
        logic [6:0]  vl;
        logic [1:0]  sv;
        logic        kind;
        logic [2:0]  sel;
        logic        zen;
        logic [63:0] r3;
        logic [63:0] r10;
        logic [63:0] r30;
        logic [63:0] crseed;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{7'd8,  2'd0, 1'b0, 3'd0, 1'b0, 64'h0, 64'h0, 64'h0, 64'h0},
        '{7'd16, 2'd0, 1'b0, 3'd2, 1'b0, 64'hA5A5_0F0F_3C3C_9696, 64'h0, 64'h0, 64'h0},
        '{7'd12, 2'd1, 1'b0, 3'd3, 1'b1, 64'h0000_0000_0000_0C35, 64'h0, 64'h0, 64'h0},
        '{7'd10, 2'd2, 1'b0, 3'd4, 1'b1, 64'h0, 64'h0000_0000_0000_0259, 64'h0, 64'h0},
        '{7'd9,  2'd3, 1'b0, 3'd5, 1'b0, 64'h0, 64'h0000_0000_0000_0131, 64'h0, 64'h0},
        '{7'd20, 2'd0, 1'b0, 3'd6, 1'b1, 64'h0, 64'h0, 64'h0000_0000_000F_0E1D, 64'h0},
        '{7'd20, 2'd0, 1'b0, 3'd7, 1'b0, 64'h0, 64'h0, 64'h0000_0000_000F_0E1D, 64'h0},
        '{7'd8,  2'd0, 1'b0, 3'd1, 1'b1, 64'd5, 64'h0, 64'h0, 64'h0},
        '{7'd64, 2'd0, 1'b0, 3'd1, 1'b0, 64'd63, 64'h0, 64'h0, 64'h0},
        '{7'd6,  2'd0, 1'b0, 3'd1, 1'b1, 64'd70, 64'h0, 64'h0, 64'h0},
        '{7'd16, 2'd0, 1'b1, 3'd0, 1'b0, 64'h0, 64'h0, 64'h0, 64'h1234_5678_9ABC_DEF0},
        '{7'd16, 2'd1, 1'b1, 3'd1, 1'b1, 64'h0, 64'h0, 64'h0, 64'h0F1E_2D3C_4B5A_6978},
        '{7'd16, 2'd0, 1'b1, 3'd2, 1'b1, 64'h0, 64'h0, 64'h0, 64'hCAFE_F00D_1357_2468},
        '{7'd16, 2'd2, 1'b1, 3'd3, 1'b0, 64'h0, 64'h0, 64'h0, 64'h8421_8421_0000_FFFF},
        '{7'd16, 2'd0, 1'b1, 3'd4, 1'b0, 64'h0, 64'h0, 64'h0, 64'h5555_AAAA_3333_CCCC},
        '{7'd16, 2'd3, 1'b1, 3'd5, 1'b1, 64'h0, 64'h0, 64'h0, 64'h0123_4567_89AB_CDEF},
        '{7'd16, 2'd0, 1'b1, 3'd6, 1'b1, 64'h0, 64'h0, 64'h0, 64'hFEDC_BA98_7654_3210},
        '{7'd16, 2'd1, 1'b1, 3'd7, 1'b0, 64'h0, 64'h0, 64'h0, 64'h7E7E_8181_E7E7_1818},
        '{7'd64, 2'd0, 1'b0, 3'd2, 1'b1, 64'hF0E1_D2C3_B4A5_9687, 64'h0, 64'h0, 64'h0},
        '{7'd1,  2'd0, 1'b0, 3'd0, 1'b0, 64'h0, 64'h0, 64'h0, 64'h0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [6:0]   vec_len = '0;
    logic [1:0]   subvec_code = '0;
    logic         pred_kind = 1'b0;
    logic [2:0]   pred_sel = '0;
    logic         zero_en = 1'b0;
    logic [63:0]  src_r3 = '0, src_r10 = '0, src_r30 = '0;
    logic [255:0] cond_fields = '0;
    logic         busy, elem_valid, elem_zero, elem_skip, done;
    logic [5:0]   elem_idx;
    logic [1:0]   sub_idx;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pred_elem_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .subvec_code(subvec_code), .pred_kind(pred_kind), .pred_sel(pred_sel),
        .zero_en(zero_en), .src_r3(src_r3), .src_r10(src_r10), .src_r30(src_r30),
        .cond_fields(cond_fields), .busy(busy), .elem_valid(elem_valid),
        .elem_zero(elem_zero), .elem_skip(elem_skip), .elem_idx(elem_idx),
        .sub_idx(sub_idx), .done(done)
    );

    function automatic logic [255:0] make_cf(input logic [63:0] seed);
        logic [255:0] v;
        for (int f = 0; f < 64; f++)
            v[4*f +: 4] = seed[(f*4) % 64 +: 4] ^ 4'(f);
        return v;
    endfunction

    function automatic logic pred_of(input logic kind, input logic [2:0] sel, input int i,
                                     input logic [63:0] a, input logic [63:0] b,
                                     input logic [63:0] c, input logic [255:0] cf);
        logic [3:0] nib;
        logic f;
        if (kind) begin
            nib = cf[4*i +: 4];
            f = nib[3 - int'(sel[2:1])];
            return f ^ sel[0];
        end
        case (sel)
            3'd0: return 1'b1;
            3'd1: return (a == 64'(i));
            3'd2: return a[i];
            3'd3: return ~a[i];
            3'd4: return b[i];
            3'd5: return ~b[i];
            3'd6: return c[i];
            default: return ~c[i];
        endcase
    endfunction

    task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got busy/done/v/z/s/idx/sub=%b expected %b", req, act, exp);
        end
    endtask

    // mode 0: plain, 1: start pulse mid-run, 2: sources changed mid-run
    task automatic run_case(input logic [6:0] vl, input logic [1:0] sv, input logic kind,
                            input logic [2:0] sel, input logic zen, input int mode, input string req);
        logic [63:0] a, b, c;
        logic [255:0] cf;
        int n;
        logic p;
        logic [12:0] exp;
        a = src_r3; b = src_r10; c = src_r30; cf = cond_fields;
        n = (vl > 7'd64) ? 64 : int'(vl);
        @(negedge clk);
        vec_len = vl; subvec_code = sv; pred_kind = kind; pred_sel = sel; zero_en = zen;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            p = pred_of(kind, sel, i, a, b, c, cf);
            for (int s = 0; s <= int'(sv); s++) begin
                exp = {1'b1, 1'b0, p, ~p & zen, ~p & ~zen, 6'(i), 2'(s)};
                chk(req, {busy, done, elem_valid, elem_zero, elem_skip, elem_idx, sub_idx}, exp);
                if (i == 0 && s == 0 && mode == 1) begin
                    start = 1'b1; vec_len = 7'd1; pred_sel = 3'd7;
                end
                if (i == 0 && s == 0 && mode == 2) begin
                    src_r3 = ~src_r3; src_r10 = ~src_r10; src_r30 = ~src_r30;
                    cond_fields = ~cond_fields;
                end
                @(negedge clk);
                start = 1'b0;
            end
        end
        chk({req, " R9 done"}, {busy, done, elem_valid, elem_zero, elem_skip, 8'd0},
            {1'b0, 1'b1, 3'b000, 8'd0});
        @(negedge clk);
        chk("R9 pulse", {busy, done, elem_valid, elem_zero, elem_skip, 8'd0}, 13'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R2: idle means no indication
        chk("R2 reset", {busy, done, elem_valid, elem_zero, elem_skip, elem_idx, sub_idx}, 13'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle", {busy, done, elem_valid, elem_zero, elem_skip, elem_idx, sub_idx}, 13'd0);

        // table walk: R1 R3 R4 R5 R6 R7 R12
        for (int k = 0; k < NV; k++) begin
            src_r3 = TBL[k].r3; src_r10 = TBL[k].r10; src_r30 = TBL[k].r30;
            cond_fields = make_cf(TBL[k].crseed);
            run_case(TBL[k].vl, TBL[k].sv, TBL[k].kind, TBL[k].sel, TBL[k].zen, 0,
                     TBL[k].kind ? "R5 R6 R7" : (TBL[k].sel == 3'd1 ? "R4 R7" :
                     (TBL[k].vl == 7'd1 ? "R12" : "R1 R3 R6 R7")));
        end

        // R8: zero length
        @(negedge clk);
        vec_len = 7'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 empty", {busy, done, elem_valid, elem_zero, elem_skip, 8'd0}, {1'b0, 1'b1, 3'b000, 8'd0});
        @(negedge clk);
        chk("R8 after", {busy, done, elem_valid, elem_zero, elem_skip, 8'd0}, 13'd0);

        // R10: start while busy ignored
        src_r3 = 64'h0000_0000_0000_0006;
        run_case(7'd5, 2'd1, 1'b0, 3'd2, 1'b1, 1, "R10");

        // R11: sources changed during a run
        src_r3 = 64'h0000_0000_0000_00B3; src_r10 = 64'h0; src_r30 = 64'h0;
        run_case(7'd8, 2'd0, 1'b0, 3'd2, 1'b0, 2, "R11 int");
        cond_fields = make_cf(64'h1357_9BDF_0246_8ACE);
        run_case(7'd8, 2'd0, 1'b1, 3'd4, 1'b1, 2, "R11 cond");

        // R1: length above 64 clamps
        run_case(7'd127, 2'd0, 1'b0, 3'd0, 1'b0, 0, "R1 clamp");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule